// File: doc/BRIEF.md
# ROM-Lookup Coefficient Multiply-Accumulate Cell

This cell is one stage of a linear systolic array that evaluates a prime-length cosine transform as a pair of convolutions. Each cell owns one fixed coefficient, a fixed-point value of 2·cos(kπ/N). The cell multiplies the coefficient by an operand and folds the product into two running sums that pass through the array. A small dual-read lookup table replaces the multiplier. Its index is half the operand width. Each entry holds the coefficient times a half-width number whose bits are spread onto the even bit positions. The operand magnitude is split into its even-position bits and its odd-position bits. Both sub-words read the table in the same cycle. The odd-position result is then moved up one place and added to the even-position result.

Two tags control each cell. A select tag picks which of two incoming operands drives the table. A negate tag decides whether the product is subtracted from the first running sum or added to it. The second running sum always receives the product with the operand's own sign. The operands, the tags and the sums leave the cell four clock cycles after they enter, so the next cell sees each operand together with its own control. The cell accepts a new operand every cycle.

Top module: `dct_rom_pe`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both sum outputs read zero and both tag outputs read zero.
- R2: Four cycles after an input cycle, sum1 out equals sum1 in plus C·a when the negate tag is 0, and sum1 in minus C·a when it is 1. Here C is the signed coefficient and a is the selected operand.
- R3: Four cycles after an input cycle, sum2 out equals sum2 in plus C·a, whatever the value of the negate tag.
- R4: Select tag value 0 chooses operand 0 and value 1 chooses operand 1. The unselected operand has no effect on either sum output.
- R5: Both operands and both tags appear at the outputs unchanged, four cycles after they enter.
- R6: Results are exact over the whole two's-complement operand range, including the most negative value -2^(W-1).
- R7: Results are exact for both positive and negative coefficients.
- R8: When the selected operand is zero, both sums pass through unchanged after four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op0_i | input | W | Operand 0, signed |
| op1_i | input | W | Operand 1, signed |
| sel_i | input | 1 | Operand select tag |
| neg_i | input | 1 | Negate tag for sum1 |
| y1_i | input | YW | Incoming running sum 1 |
| y2_i | input | YW | Incoming running sum 2 |
| op0_o | output | W | Operand 0 delayed by four cycles |
| op1_o | output | W | Operand 1 delayed by four cycles |
| sel_o | output | 1 | Select tag delayed by four cycles |
| neg_o | output | 1 | Negate tag delayed by four cycles |
| y1_o | output | YW | Updated running sum 1 |
| y2_o | output | YW | Updated running sum 2 |

## Verification
The bench drives every 8-bit operand value, once for each of the four tag combinations. The operands stream back-to-back, and two cells run side by side, one with a positive coefficient and one with a negative coefficient. Values with set bits only in even positions, or only in odd positions, exercise each table read on its own. Mixed values test whether the shifted recombination is correct. The most negative operand tests whether magnitude formation is exact. The second operand always carries an unrelated value, so any leak from the unselected operand shows up as a sum mismatch. Opposite settings of the negate tag separate the two sum paths.

// File: rtl/dct_rom_pe.sv
`timescale 1ns/1ps
module dct_rom_pe #(
  parameter int W    = 8,
  parameter int CW   = 10,
  parameter int COEF = 231,
  parameter int YW   = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op0_i,
  input  logic [W-1:0]  op1_i,
  input  logic          sel_i,
  input  logic          neg_i,
  input  logic [YW-1:0] y1_i,
  input  logic [YW-1:0] y2_i,
  output logic [W-1:0]  op0_o,
  output logic [W-1:0]  op1_o,
  output logic          sel_o,
  output logic          neg_o,
  output logic [YW-1:0] y1_o,
  output logic [YW-1:0] y2_o
);
  localparam int H  = W / 2;
  localparam int TW = CW + W;
  localparam int PW = TW + 1;
  localparam int D  = 4;
  localparam logic signed [CW-1:0] KC = CW'(COEF);

  function automatic logic [W-1:0] spread(input logic [H-1:0] idx);
    logic [W-1:0] r;
    r = '0;
    for (int j = 0; j < H; j++) r[2*j] = idx[j];
    return r;
  endfunction

  logic signed [TW-1:0] tbl [2**H];
  for (genvar g = 0; g < 2**H; g++) begin : g_tbl
    assign tbl[g] = TW'(KC) * TW'($signed({1'b0, spread(H'(g))}));
  end

  logic [W-1:0] opsel, mag;
  assign opsel = sel_i ? op1_i : op0_i;
  assign mag   = opsel[W-1] ? (~opsel + W'(1)) : opsel;

  logic [W-1:0] mag1;
  logic         sg1, n1, sg2, n2;
  logic [H-1:0] ev, od;
  for (genvar j = 0; j < H; j++) begin : g_split
    assign ev[j] = mag1[2*j];
    assign od[j] = mag1[2*j+1];
  end

  logic signed [TW-1:0] pe2, po2;
  logic signed [PW-1:0] prod, c1_3, c2_3;
  assign prod = PW'(pe2) + (PW'(po2) <<< 1);

  logic [YW-1:0] y1d [D-1];
  logic [YW-1:0] y2d [D-1];
  logic [W-1:0]  op0d [D];
  logic [W-1:0]  op1d [D];
  logic [D-1:0]  seld, negd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag1 <= '0; sg1 <= 1'b0; n1 <= 1'b0;
      pe2 <= '0; po2 <= '0; sg2 <= 1'b0; n2 <= 1'b0;
      c1_3 <= '0; c2_3 <= '0;
      y1_o <= '0; y2_o <= '0;
      seld <= '0; negd <= '0;
      for (int i = 0; i < D-1; i++) begin y1d[i] <= '0; y2d[i] <= '0; end
      for (int i = 0; i < D; i++) begin op0d[i] <= '0; op1d[i] <= '0; end
    end else begin
      mag1 <= mag; sg1 <= opsel[W-1]; n1 <= neg_i;
      pe2 <= tbl[ev]; po2 <= tbl[od]; sg2 <= sg1; n2 <= n1;
      c1_3 <= (sg2 ^ n2) ? -prod : prod;
      c2_3 <= sg2 ? -prod : prod;
      y1_o <= y1d[D-2] + YW'(c1_3);
      y2_o <= y2d[D-2] + YW'(c2_3);
      y1d[0] <= y1_i; y2d[0] <= y2_i;
      for (int i = 1; i < D-1; i++) begin y1d[i] <= y1d[i-1]; y2d[i] <= y2d[i-1]; end
      op0d[0] <= op0_i; op1d[0] <= op1_i;
      for (int i = 1; i < D; i++) begin op0d[i] <= op0d[i-1]; op1d[i] <= op1d[i-1]; end
      seld <= {seld[D-2:0], sel_i};
      negd <= {negd[D-2:0], neg_i};
    end
  end

  assign op0_o = op0d[D-1];
  assign op1_o = op1d[D-1];
  assign sel_o = seld[D-1];
  assign neg_o = negd[D-1];

  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (y1_o == '0 && y2_o == '0 && !sel_o && !neg_o));

  a_r5_tag_travel: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4) |-> (sel_o == $past(sel_i, 4) && neg_o == $past(neg_i, 4)
                        && op0_o == $past(op0_i, 4) && op1_o == $past(op1_i, 4)));

  a_r3_same_when_add: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && !neg_o) |->
      (YW'(y1_o - $past(y1_i, 4)) == YW'(y2_o - $past(y2_i, 4))));

  a_r2_opposite_when_neg: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && neg_o) |->
      (YW'((y1_o - $past(y1_i, 4)) + (y2_o - $past(y2_i, 4))) == '0));

  a_r8_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && ((sel_o ? op1_o : op0_o) == '0)) |->
      (y1_o == $past(y1_i, 4) && y2_o == $past(y2_i, 4)));
endmodule

// File: tb/tb_dct_rom_pe.sv
`timescale 1ns/1ps
module tb_dct_rom_pe;
  localparam int W = 8, CW = 10, YW = 24;
  localparam int CP = 231, CN = -145;
  localparam int NS = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] op0_i = '0, op1_i = '0;
  logic sel_i = 1'b0, neg_i = 1'b0;
  logic [YW-1:0] y1_i = '0, y2_i = '0;
  logic [W-1:0] op0_o, op1_o, op0_n, op1_n;
  logic sel_o, neg_o, sel_n, neg_n;
  logic [YW-1:0] y1_o, y2_o, y1_n, y2_n;

  int errors = 0, checks = 0;
  int e1p [NS], e2p [NS], e1n [NS], e2n [NS], ea0 [NS], ea1 [NS], es [NS], en [NS], esel [NS];

  always #2 clk = ~clk;

  dct_rom_pe #(.W(W), .CW(CW), .COEF(CP), .YW(YW)) dut (
    .clk(clk), .rst(rst), .op0_i(op0_i), .op1_i(op1_i), .sel_i(sel_i), .neg_i(neg_i),
    .y1_i(y1_i), .y2_i(y2_i), .op0_o(op0_o), .op1_o(op1_o), .sel_o(sel_o),
    .neg_o(neg_o), .y1_o(y1_o), .y2_o(y2_o));

  dct_rom_pe #(.W(W), .CW(CW), .COEF(CN), .YW(YW)) dut_neg (
    .clk(clk), .rst(rst), .op0_i(op0_i), .op1_i(op1_i), .sel_i(sel_i), .neg_i(neg_i),
    .y1_i(y1_i), .y2_i(y2_i), .op0_o(op0_n), .op1_o(op1_n), .sel_o(sel_n),
    .neg_o(neg_n), .y1_o(y1_n), .y2_o(y2_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 y1", int'($signed(y1_o)), 0);
    chk("R1 y2", int'($signed(y2_n)), 0);
    chk("R1 tags", int'({sel_o, neg_o, sel_n, neg_n}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", int'($signed(y1_o)) + int'($signed(y2_o)), 0);
    for (int n = 0; n < NS + 4; n++) begin
      if (n >= 4) begin
        int k;
        k = n - 4;
        chk(ea0[k] == -128 || ea1[k] == -128 ? "R6 R2 sum1 pos" : "R2 R4 sum1 pos",
            int'($signed(y1_o)), e1p[k]);
        chk("R3 R4 sum2 pos", int'($signed(y2_o)), e2p[k]);
        chk("R7 R2 sum1 neg coef", int'($signed(y1_n)), e1n[k]);
        chk(esel[k] == 0 ? "R8 R7 sum2 neg coef" : "R7 R3 sum2 neg coef",
            int'($signed(y2_n)), e2n[k]);
        chk("R5 pass", int'({$signed(op0_o), $signed(op1_o), sel_o, neg_o}),
            int'({8'(ea0[k]), 8'(ea1[k]), 1'(es[k]), 1'(en[k])}));
      end
      if (n < NS) begin
        int v, a0, a1, a, s, y1, y2;
        logic signed [7:0] t;
        v  = (n >>> 2) - 128;
        t  = 8'(v * 5 + 3);
        a0 = v; a1 = int'(t);
        s  = n & 1;
        y1 = ((n * 37) % 5000) - 2500;
        y2 = 1000 - n * 3;
        a  = s ? a1 : a0;
        op0_i = 8'(a0); op1_i = 8'(a1);
        sel_i = s[0]; neg_i = n[1];
        y1_i = YW'(y1); y2_i = YW'(y2);
        ea0[n] = a0; ea1[n] = a1; es[n] = s; en[n] = (n >> 1) & 1; esel[n] = a;
        e1p[n] = y1 + (n[1] ? -1 : 1) * CP * a;
        e2p[n] = y2 + CP * a;
        e1n[n] = y1 + (n[1] ? -1 : 1) * CN * a;
        e2n[n] = y2 + CN * a;
      end else begin
        op0_i = '0; op1_i = '0; sel_i = 1'b0; neg_i = 1'b0; y1_i = '0; y2_i = '0;
      end
      @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule